// File: doc/BRIEF.md
# Nine-bit DBI word packer

This block prepares traffic for the three-wire serial display bus when the serial transmitter behind it can only shift whole bytes. Every incoming byte carries a flag that marks it as a command or as data. The block turns each byte into a nine-bit word: the flag bit comes first, followed by the eight payload bits, most significant bit first. It then packs eight such words into one block of nine bytes that the byte transmitter can send unchanged. Padding always uses the no-op word, which is nine zero bits.

A command forms a block on its own. The command word goes in the final slot and seven no-op words come before it. Data bytes fill slots in the order they arrive. A block is released when all eight slots are full or when the byte flagged as last arrives, and any slots still empty at that point hold no-ops. Bytes are packed in arrival order, so for sixteen-bit pixels the source must present the high byte of each pixel before its low byte. Both the input and the output are valid/ready streams. While the block is draining, the input is held off, so no bit is lost under backpressure.

The controller has two states. In `ST_FILL` it accepts bytes (`in_ready` high) and writes them into word slots. The transition FILL→DRAIN happens on an accepted command, on an accepted data byte flagged last, or on an accepted data byte that fills the eighth slot. In `ST_DRAIN` it presents the nine block bytes one at a time (`out_valid` high). The transition DRAIN→FILL happens when the ninth byte is accepted, and the same edge clears all slots to the no-op word.

Top module: `dbi9_packer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: A data byte B (`in_dc`=1) becomes the nine-bit word {1, B[7:0]}, flag bit first. A single data byte 0x80 sent with `in_last` therefore yields the bytes C0 followed by eight 00.
- R3: Eight data words W0..W7 produce exactly nine output bytes. Output byte k holds bits 8k to 8k+7 of the 72-bit string W0 W1 … W7, with each word written most significant bit (the flag) first.
- R4: A command byte C (`in_dc`=0) produces a block whose first seven words are 9'h000 and whose eighth word is {0, C}. The output is seven bytes of 00, then 00, then C. `in_last` has no effect on a command.
- R5: A data byte accepted with `in_last`=1 closes the block. Every slot not yet written is sent as the no-op word 9'h000.
- R6: No output byte is offered while a block is still filling, that is, after fewer than eight data bytes without `in_last`.
- R7: While `out_valid`=1 and `out_ready`=0, `out_valid` stays 1 and `out_byte` does not change on the next cycle.
- R8: `in_ready` is 0 while `out_valid` is 1. Bytes presented during draining are not taken and do not appear in the output.
- R9: A data byte with `in_last` that also fills the eighth slot yields exactly one nine-byte block, with no extra padding block.
- R10: On the cycle after the ninth byte of a block is accepted, `in_ready` is 1 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte is present |
| in_ready | output | 1 | Block can accept an input byte |
| in_byte | input | 8 | Payload byte |
| in_dc | input | 1 | 1 = data, 0 = command |
| in_last | input | 1 | Final data byte of a run; pads the open block |
| out_valid | output | 1 | Output byte is present |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_byte | output | 8 | Packed output byte, block byte 0 first |

## Verification
The assertions assume that a command byte arrives only when no data block is partly filled. That means it comes after a data run closed by `in_last`, or after an exact multiple of eight data bytes. Without this, the command would share a block with stale data. The bench meets the assumption by sending every data run either with a closing `in_last` or in whole groups of eight before any command. It also keeps `in_valid` and the payload steady until the byte is accepted, which the backpressure checks on the output side rely on.

// File: rtl/dbi9_pkg.sv
package dbi9_pkg;
    typedef enum logic {
        ST_FILL  = 1'b0,
        ST_DRAIN = 1'b1
    } pk_state_e;
endpackage

// File: rtl/dbi9_block_reg.sv
// Holds the eight nine-bit word slots of one block; slot 0 is most significant.
module dbi9_block_reg #(
    parameter int BYTE_W     = 8,
    parameter int WORD_W     = BYTE_W + 1,
    parameter int IDX_W      = $clog2(BYTE_W),
    parameter int BLOCK_BITS = WORD_W * BYTE_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [WORD_W-1:0]     wr_word,
    output logic [BLOCK_BITS-1:0] block
);
    logic [WORD_W-1:0] slot_q [BYTE_W];

    for (genvar g = 0; g < BYTE_W; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (clear) begin
                slot_q[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                slot_q[g] <= wr_word;
            end
        end
        assign block[BLOCK_BITS-1-g*WORD_W -: WORD_W] = slot_q[g];
    end
endmodule

// File: rtl/dbi9_byte_sel.sv
// Picks output byte rd_idx of the packed block, byte 0 taken from the top bits.
module dbi9_byte_sel #(
    parameter int BYTE_W     = 8,
    parameter int WORD_W     = BYTE_W + 1,
    parameter int RD_W       = $clog2(WORD_W),
    parameter int BLOCK_BITS = WORD_W * BYTE_W
) (
    input  logic [BLOCK_BITS-1:0] block,
    input  logic [RD_W-1:0]       rd_idx,
    output logic [BYTE_W-1:0]     out_byte
);
    logic [BYTE_W-1:0] lanes [WORD_W];

    for (genvar g = 0; g < WORD_W; g++) begin : g_lane
        assign lanes[g] = block[BLOCK_BITS-1-g*BYTE_W -: BYTE_W];
    end

    always_comb begin
        out_byte = '0;
        for (int k = 0; k < WORD_W; k++) begin
            if (rd_idx == RD_W'(k)) begin
                out_byte = lanes[k];
            end
        end
    end
endmodule

// File: rtl/dbi9_ctrl.sv
// Fill/drain sequencer of the packer.
module dbi9_ctrl
    import dbi9_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int IDX_W  = $clog2(BYTE_W),
    parameter int RD_W   = $clog2(BYTE_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_dc,
    input  logic             in_last,
    input  logic             out_ready,
    output logic             in_ready,
    output logic             out_valid,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic             clear,
    output logic [RD_W-1:0]  rd_idx
);
    localparam logic [IDX_W-1:0] FILL_LAST = IDX_W'(BYTE_W - 1);
    localparam logic [RD_W-1:0]  RD_LAST   = RD_W'(BYTE_W);

    pk_state_e        st_q, st_d;
    logic [IDX_W-1:0] fill_q;
    logic [RD_W-1:0]  rd_q;
    logic             in_fire, out_fire, close_blk, drain_done;

    assign in_fire    = in_valid && (st_q == ST_FILL);
    assign out_fire   = out_ready && (st_q == ST_DRAIN);
    assign close_blk  = in_fire && (!in_dc || in_last || (fill_q == FILL_LAST));
    assign drain_done = out_fire && (rd_q == RD_LAST);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_FILL:  if (close_blk)  st_d = ST_DRAIN;
            ST_DRAIN: if (drain_done) st_d = ST_FILL;
            default:  st_d = ST_FILL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_FILL;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= '0;
            rd_q   <= '0;
        end else begin
            if (in_fire) begin
                fill_q <= close_blk ? '0 : fill_q + 1'b1;
            end
            if (out_fire) begin
                rd_q <= drain_done ? '0 : rd_q + 1'b1;
            end
        end
    end

    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        wr_en     = 1'b0;
        clear     = 1'b0;
        wr_idx    = in_dc ? fill_q : FILL_LAST;
        rd_idx    = rd_q;
        unique case (st_q)
            ST_FILL: begin
                in_ready = 1'b1;
                wr_en    = in_valid;
            end
            ST_DRAIN: begin
                out_valid = 1'b1;
                clear     = drain_done;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dbi9_packer.sv
module dbi9_packer #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_dc,
    input  logic              in_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] out_byte
);
    localparam int WORD_W     = BYTE_W + 1;
    localparam int IDX_W      = $clog2(BYTE_W);
    localparam int RD_W       = $clog2(WORD_W);
    localparam int BLOCK_BITS = WORD_W * BYTE_W;

    logic                  wr_en, clear;
    logic [IDX_W-1:0]      wr_idx;
    logic [RD_W-1:0]       rd_idx;
    logic [BLOCK_BITS-1:0] block;

    dbi9_ctrl #(.BYTE_W(BYTE_W), .IDX_W(IDX_W), .RD_W(RD_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_dc(in_dc), .in_last(in_last),
        .out_ready(out_ready), .in_ready(in_ready), .out_valid(out_valid),
        .wr_en(wr_en), .wr_idx(wr_idx), .clear(clear), .rd_idx(rd_idx)
    );

    dbi9_block_reg #(.BYTE_W(BYTE_W), .WORD_W(WORD_W), .IDX_W(IDX_W),
                     .BLOCK_BITS(BLOCK_BITS)) u_blk (
        .clk(clk), .rst_n(rst_n), .clear(clear), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_word({in_dc, in_byte}), .block(block)
    );

    dbi9_byte_sel #(.BYTE_W(BYTE_W), .WORD_W(WORD_W), .RD_W(RD_W),
                    .BLOCK_BITS(BLOCK_BITS)) u_sel (
        .block(block), .rd_idx(rd_idx), .out_byte(out_byte)
    );
endmodule

// File: rtl/dbi9_packer_chk.sv
module dbi9_packer_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_dc,
    input logic              in_last,
    input logic              out_valid,
    input logic              out_ready,
    input logic [BYTE_W-1:0] out_byte
);
    int ocnt;
    int wcnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ocnt <= 0;
            wcnt <= 0;
        end else begin
            if (out_valid && out_ready) begin
                ocnt <= (ocnt == BYTE_W) ? 0 : ocnt + 1;
            end
            if (out_valid) begin
                wcnt <= 0;
            end else if (in_valid && in_ready && in_dc) begin
                wcnt <= wcnt + 1;
            end
        end
    end

    a_r3_block_len: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (ocnt == 0));

    a_r4_cmd_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_dc) |=> out_valid);

    a_r5_last_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_last) |=> out_valid);

    a_r6_no_early: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_dc && !in_last && (wcnt < BYTE_W - 1)) |=> !out_valid);

    a_r7_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid);

    a_r7_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> $stable(out_byte));

    a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    a_r10_reopen: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && (ocnt == BYTE_W)) |=> (in_ready && !out_valid));
endmodule

bind dbi9_packer dbi9_packer_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_dc(in_dc), .in_last(in_last), .out_valid(out_valid),
    .out_ready(out_ready), .out_byte(out_byte)
);

// File: tb/tb_dbi9_packer.sv
module tb_dbi9_packer;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid, in_ready, in_dc, in_last;
    logic [7:0] in_byte;
    logic       out_valid, out_ready;
    logic [7:0] out_byte;

    int         checks = 0;
    int         fails  = 0;
    int         rdy_mode = 0;
    int         mcyc = 0;
    logic [7:0] mexp;
    string      mtag;
    logic [7:0] held;

    logic [8:0] mdl_q [$];
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #4 clk = ~clk;

    dbi9_packer dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_byte(in_byte), .in_dc(in_dc), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte)
    );

    task automatic finish_up();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Builds the expected bytes by serialising the words bit by bit.
    task automatic emit_block(input string tag);
        logic       bits [$];
        logic [7:0] b;
        while (mdl_q.size() < 8) mdl_q.push_back(9'h000);
        foreach (mdl_q[i]) begin
            for (int k = 8; k >= 0; k--) bits.push_back(mdl_q[i][k]);
        end
        for (int n = 0; n < 9; n++) begin
            b = '0;
            for (int k = 0; k < 8; k++) b = {b[6:0], bits[n*8+k]};
            exp_q.push_back(b);
            tag_q.push_back(tag);
        end
        mdl_q.delete();
    endtask

    task automatic drive(input logic [7:0] b, input logic dc, input logic last);
        bit acc;
        in_valid = 1'b1;
        in_byte  = b;
        in_dc    = dc;
        in_last  = last;
        do begin
            #1 acc = in_ready;
            @(negedge clk);
        end while (!acc);
    endtask

    task automatic send_data(input logic [7:0] b, input logic last, input string tag);
        mdl_q.push_back({1'b1, b});
        if (mdl_q.size() == 8 || last) emit_block(tag);
        drive(b, 1'b1, last);
    endtask

    task automatic send_cmd(input logic [7:0] c, input string tag);
        for (int i = 0; i < 7; i++) mdl_q.push_back(9'h000);
        mdl_q.push_back({1'b0, c});
        emit_block(tag);
        drive(c, 1'b0, 1'b1);
    endtask

    task automatic wait_drain(input string tag);
        in_valid = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        #2;
        chk({tag, " R10 in_ready after block"}, 32'(in_ready), 32'd1);
        chk({tag, " R10 out_valid after block"}, 32'(out_valid), 32'd0);
    endtask

    // Monitor: drives out_ready and pops the scoreboard on every handshake.
    initial begin
        out_ready = 1'b0;
        forever begin
            @(negedge clk);
            case (rdy_mode)
                0:       out_ready = 1'b1;
                1:       out_ready = 1'b0;
                default: out_ready = (mcyc % 3) != 1;
            endcase
            mcyc++;
            #1;
            if (rst_n && out_valid && out_ready) begin
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R8 unexpected byte actual %02h expected none", out_byte);
                end else begin
                    mexp = exp_q.pop_front();
                    mtag = tag_q.pop_front();
                    if (out_byte !== mexp) begin
                        fails++;
                        $display("FAIL %s actual %02h expected %02h", mtag, out_byte, mexp);
                    end
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog (all requirements) actual hung expected done");
        finish_up();
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_byte = '0; in_dc = 1'b0; in_last = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 out_valid in reset", 32'(out_valid), 32'd0);
        chk("R1 in_ready in reset", 32'(in_ready), 32'd1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R1 out_valid after reset", 32'(out_valid), 32'd0);
        chk("R1 in_ready after reset", 32'(in_ready), 32'd1);
        @(negedge clk);

        // R2: single data word with its flag bit first
        send_data(8'h80, 1'b1, "R2");
        wait_drain("R2");

        // R4: commands, back to back, placed in the last slot
        send_cmd(8'h2A, "R4");
        send_cmd(8'hFF, "R4");
        wait_drain("R4");

        // R3: full group of eight under irregular backpressure
        rdy_mode = 2;
        for (int i = 0; i < 8; i++) send_data(8'(i * 8'h11) ^ 8'hA5, 1'b0, "R3");
        wait_drain("R3");

        // R5: partial run padded at its end
        send_data(8'h3C, 1'b0, "R5");
        send_data(8'hC3, 1'b0, "R5");
        send_data(8'h01, 1'b1, "R5");
        wait_drain("R5");

        // R9: last on the eighth byte gives a single block
        rdy_mode = 0;
        for (int i = 0; i < 8; i++) send_data(8'hF0 - 8'(i), i == 7, "R9");
        wait_drain("R9");
        repeat (3) @(negedge clk);
        #2;
        chk("R9 no padding block", 32'(out_valid), 32'd0);
        @(negedge clk);

        // R3: pixel stream, high byte first, then a command
        rdy_mode = 2;
        for (int i = 0; i < 8; i++) begin
            send_data(8'h12 + 8'(i), 1'b0, "R3");
            send_data(8'hE0 ^ 8'(i), 1'b0, "R3");
        end
        send_cmd(8'h2C, "R4");
        wait_drain("R3");

        // R6, R7, R8: output stalled
        rdy_mode = 1;
        @(negedge clk);
        send_data(8'h55, 1'b0, "R6");
        send_data(8'hAA, 1'b0, "R6");
        send_data(8'h0F, 1'b0, "R6");
        in_valid = 1'b0;
        @(negedge clk);
        #2;
        chk("R6 no output while filling", 32'(out_valid), 32'd0);
        @(negedge clk);
        send_data(8'hF0, 1'b1, "R7");
        in_valid = 1'b0;
        #2;
        chk("R6 block formed", 32'(out_valid), 32'd1);
        chk("R8 in_ready low while draining", 32'(in_ready), 32'd0);
        chk("R7 first byte", 32'(out_byte), 32'(exp_q[0]));
        held = out_byte;
        @(negedge clk);
        in_valid = 1'b1; in_byte = 8'hEE; in_dc = 1'b1; in_last = 1'b1;
        repeat (3) begin
            @(negedge clk);
            #2;
            chk("R7 valid held", 32'(out_valid), 32'd1);
            chk("R7 byte held", 32'(out_byte), 32'(held));
            chk("R8 input refused", 32'(in_ready), 32'd0);
        end
        in_valid = 1'b0;
        @(negedge clk);
        rdy_mode = 2;
        wait_drain("R8");

        repeat (4) @(negedge clk);
        finish_up();
    end
endmodule